// File: doc/BRIEF.md
# Two-Word Floating Add/Subtract Unit

This unit adds or subtracts two packed 32-bit floating values held in a two-word legacy format. The sign is not a separate field. It is the top bit of a 24-bit two's-complement fraction that fills bits 31..8. Bits 7..1 hold the low seven bits of an 8-bit two's-complement exponent, and bit 0 holds that exponent's sign. The value of a word is fraction × 2^exponent, and the fraction lies in [-1, 1).

Operand 1 arrives as two 16-bit halves: `a_i` is the upper half and `b_i` is the lower half. Operand 2 arrives as one 32-bit word. A one-cycle `start_i` launches the operation.

The unit works through these steps in order:
1. Unpack both operands.
2. Negate operand 2 when subtracting.
3. Order the operands by exponent alone.
4. Align the smaller-exponent fraction with a single-cycle arithmetic barrel shift.
5. Add, repairing a like-sign carry-out with a one-bit right shift.
6. Normalize one bit per cycle.
7. Round by adding a sign-dependent constant, then pack with overflow and underflow detection.

The packed result appears on `a_o`/`b_o` together with `ovf_o` and a one-cycle `done_o`. The result stays there until the next operation completes.

Top module: `fpas_unit`

## Requirements
- R1: Operand word layout: bits 31..8 form the 24-bit two's-complement fraction (bit 31 is its sign), bits 7..1 are the exponent's low seven bits, and bit 0 is the exponent sign. The exponent therefore reads as {bit0, bits 7..1} in 8-bit two's complement, range -128..127. Results are packed in the same layout. A normal in-range result of fraction f and exponent e is {f[23:0], e[6:0], e<0}.
- R2: When `sub_i` is 1 at start, operand 2's fraction is two's-complement negated. If the negation yields 0x80000000 (negating -1.0), the fraction becomes 0x40000000 and operand 2's exponent is incremented.
- R3: If operand 1's fraction is zero, the result is operand 2. Otherwise, if operand 2's (possibly negated) fraction is zero, the result is operand 1. The exponent of a zero-fraction operand does not matter for this choice.
- R4: Operands are ordered by exponent only: the one with the larger exponent is kept. If the exponent difference is 24 or less, the other fraction is shifted arithmetically right by the difference and the two are added. A larger difference gives the kept operand unchanged.
- R5: If both fractions are positive and the sum has bit 31 set, the sum is shifted right one bit with a zero fill and the exponent rises by one. If both are negative and the sum has bit 31 clear, the sum is shifted right with bit 31 forced to 1 and the exponent rises by one.
- R6: Fractions of unlike sign are added with no correction. A nonzero sum is then normalized by shifting left (exponent decreasing) until bits 31 and 30 differ.
- R7: Rounding adds 0x80 to a positive normalized fraction or 0x7F to a negative one, then clears bits 7..0. If that changes bit 31, the fraction is shifted right one bit with the original sign placed in bit 31, and the exponent is incremented.
- R8: A zero fraction result packs as 0x00000000 with `ovf_o` = 0, regardless of any exponent.
- R9: A rounded exponent above 127 gives the word 0x7FFFFFFE with `ovf_o` = 1.
- R10: A rounded exponent below -128 gives the word 0x00000000 with `ovf_o` = 1.
- R11: `done_o` is high for exactly one cycle, at most 40 cycles after the accepted `start_i`. `a_o`, `b_o` and `ovf_o` change only in the cycle where `done_o` is high.
- R12: `sub_i` and the operands are sampled only when `start_i` is accepted. Changes to `sub_i` and any `start_i` during an operation are ignored, and a second `start_i` produces no second `done_o`.
- R13: After reset, `a_o`, `b_o`, `ovf_o` and `done_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted when idle |
| sub_i | input | 1 | 1 = subtract operand 2, 0 = add |
| a_i | input | 16 | Operand 1 upper half |
| b_i | input | 16 | Operand 1 lower half |
| opnd_i | input | 32 | Operand 2 packed word |
| a_o | output | 16 | Result upper half |
| b_o | output | 16 | Result lower half |
| ovf_o | output | 1 | Overflow or underflow of the last result |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the following edge cases:
- Negating -1.0: a unit without the rescale would return -1.0 for 0 − (-1.0).
- Like-sign carry-out in both polarities: an unrepaired carry would flip the result's sign.
- A rounding carry into the sign bit: a unit missing this would report a negative number instead of 1.0.
- Alignment exactly at and past the 24-bit limit.
- Exponent overflow and underflow at the packing limits, including underflow reached only through normalization.
- Zero fractions with nonzero exponents, which must neither steer operand ordering nor leak an exponent into a zero result.

It also toggles `sub_i` and pulses `start_i` mid-operation, which a unit sampling them late would turn into a wrong result or a spurious completion. A randomized sweep compares results against a behavioural model of the requirements.

// File: rtl/fpas_pkg.sv
package fpas_pkg;
  localparam int FR_W      = 32;
  localparam int EXP_W     = 10;
  localparam int PACK_E_W  = 7;
  localparam int MAX_ALIGN = 24;
  localparam int SH_W      = $clog2(MAX_ALIGN + 1);
  localparam int LAT_MAX   = 40;

  localparam logic [FR_W-1:0] FR_MASK  = 32'hFFFF_FF00;
  localparam logic [FR_W-1:0] SIGN_BIT = 32'h8000_0000;
  localparam logic [FR_W-1:0] RND_POS  = 32'h0000_0080;
  localparam logic [FR_W-1:0] RND_NEG  = 32'h0000_007F;
  localparam logic [FR_W-1:0] SAT_WORD = 32'h7FFF_FFFE;
  localparam int EXP_MAX = 127;
  localparam int EXP_MIN = -128;

  typedef logic signed [EXP_W-1:0] exp_t;

  typedef struct packed {
    exp_t            e;
    logic [FR_W-1:0] fr;
  } ufp_t;

  typedef enum logic [1:0] {ST_IDLE, ST_NORM, ST_PACK} state_e;

  function automatic ufp_t unpack_word(input logic [FR_W-1:0] w);
    ufp_t u;
    u.fr = w & FR_MASK;
    u.e  = {{(EXP_W-PACK_E_W){w[0]}}, w[PACK_E_W:1]};
    return u;
  endfunction
endpackage

// File: rtl/fpas_align_add.sv
module fpas_align_add
  import fpas_pkg::*;
(
  input  logic [FR_W-1:0] op1_i,
  input  logic [FR_W-1:0] op2_i,
  input  logic            sub_i,
  output ufp_t            res_o
);
  ufp_t u1, u2, big, sml;
  exp_t dif;
  logic [FR_W-1:0] sml_sh, sum;

  always_comb begin
    u1 = unpack_word(op1_i);
    u2 = unpack_word(op2_i);
    if (sub_i) begin
      u2.fr = -u2.fr;
      if (u2.fr == SIGN_BIT) begin
        u2.fr = u2.fr >> 1;
        u2.e  = u2.e + exp_t'(1);
      end
    end
    big    = u1;
    sml    = u2;
    dif    = '0;
    sml_sh = '0;
    sum    = '0;
    res_o  = u1;
    if (u1.fr == '0) begin
      res_o = u2;
    end else if (u2.fr != '0) begin
      if ($signed(u1.e) < $signed(u2.e)) begin
        big = u2;
        sml = u1;
      end
      dif   = big.e - sml.e;
      res_o = big;
      if (dif <= exp_t'(MAX_ALIGN)) begin
        sml_sh   = FR_W'($signed(sml.fr) >>> dif[SH_W-1:0]);
        sum      = big.fr + sml_sh;
        res_o.fr = sum;
        if (big.fr[FR_W-1] == sml_sh[FR_W-1]) begin
          // like signs: carry into sign bit is repaired by a one-bit right shift
          if (sml_sh[FR_W-1] && !sum[FR_W-1]) begin
            res_o.fr = {1'b1, sum[FR_W-1:1]};
            res_o.e  = big.e + exp_t'(1);
          end else if (!sml_sh[FR_W-1] && sum[FR_W-1]) begin
            res_o.fr = {1'b0, sum[FR_W-1:1]};
            res_o.e  = big.e + exp_t'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/fpas_round_pack.sv
module fpas_round_pack
  import fpas_pkg::*;
(
  input  ufp_t            norm_i,
  output logic [FR_W-1:0] word_o,
  output logic            ovf_o
);
  logic            sgn;
  logic [FR_W-1:0] rfr;
  exp_t            re;

  always_comb begin
    sgn = norm_i.fr[FR_W-1];
    rfr = (norm_i.fr + (sgn ? RND_NEG : RND_POS)) & FR_MASK;
    re  = norm_i.e;
    if (rfr[FR_W-1] != sgn) begin
      rfr = {sgn, rfr[FR_W-1:1]};
      re  = re + exp_t'(1);
    end
    ovf_o = 1'b0;
    if (rfr == '0) begin
      word_o = '0;
    end else if ($signed(re) < $signed(exp_t'(EXP_MIN))) begin
      word_o = '0;
      ovf_o  = 1'b1;
    end else if ($signed(re) > $signed(exp_t'(EXP_MAX))) begin
      word_o = SAT_WORD;
      ovf_o  = 1'b1;
    end else begin
      word_o = {rfr[FR_W-1:8], re[PACK_E_W-1:0], re[EXP_W-1]};
    end
  end
endmodule

// File: rtl/fpas_unit.sv
module fpas_unit
  import fpas_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        sub_i,
  input  logic [15:0] a_i,
  input  logic [15:0] b_i,
  input  logic [31:0] opnd_i,
  output logic [15:0] a_o,
  output logic [15:0] b_o,
  output logic        ovf_o,
  output logic        done_o
);
  state_e          st_q;
  ufp_t            cur_q, add_res;
  logic [FR_W-1:0] pk_word;
  logic            pk_ovf;

  fpas_align_add u_add (
    .op1_i (FR_W'({a_i, b_i})),
    .op2_i (opnd_i),
    .sub_i (sub_i),
    .res_o (add_res)
  );

  fpas_round_pack u_pack (
    .norm_i (cur_q),
    .word_o (pk_word),
    .ovf_o  (pk_ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cur_q  <= '0;
      a_o    <= '0;
      b_o    <= '0;
      ovf_o  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          cur_q <= add_res;
          st_q  <= ST_NORM;
        end
        ST_NORM: begin
          if (cur_q.fr == '0) begin
            cur_q.e <= '0;
            st_q    <= ST_PACK;
          end else if (cur_q.fr[FR_W-1] != cur_q.fr[FR_W-2]) begin
            st_q <= ST_PACK;
          end else begin
            cur_q.fr <= cur_q.fr << 1;
            cur_q.e  <= cur_q.e - exp_t'(1);
          end
        end
        ST_PACK: begin
          a_o    <= pk_word[31:16];
          b_o    <= pk_word[15:0];
          ovf_o  <= pk_ovf;
          done_o <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpas_unit_chk.sv
module fpas_unit_chk
  import fpas_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic [15:0] a_o,
  input logic [15:0] b_o,
  input logic        ovf_o,
  input logic        done_o
);
  logic       busy_q;
  logic [7:0] wait_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      wait_q <= '0;
    end else if (done_o) begin
      busy_q <= 1'b0;
      wait_q <= '0;
    end else if (busy_q) begin
      if (wait_q != 8'hFF) wait_q <= wait_q + 8'd1;
    end else if (start_i) begin
      busy_q <= 1'b1;
      wait_q <= 8'd1;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_DONE_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_q); // R12
  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_q <= 8'(LAT_MAX)); // R11
  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable({a_o, b_o, ovf_o})); // R11
  AST_OVF_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ovf_o) |-> ({a_o, b_o} == 32'h0 || {a_o, b_o} == SAT_WORD)); // R9
  AST_CLEAN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !ovf_o && a_o == 16'h0 && b_o[15:8] == 8'h0) |-> b_o[7:0] == 8'h0); // R8
  AST_POS_NORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !ovf_o && !a_o[15] && {a_o, b_o[15:8]} != 24'h0) |-> a_o[14]); // R6
endmodule

bind fpas_unit fpas_unit_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .a_o     (a_o),
  .b_o     (b_o),
  .ovf_o   (ovf_o),
  .done_o  (done_o)
);

// File: tb/tb_fpas_unit.sv
`timescale 1ns/1ps
module tb_fpas_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        sub_i = 1'b0;
  logic [15:0] a_i = '0, b_i = '0;
  logic [31:0] opnd_i = '0;
  logic [15:0] a_o, b_o;
  logic        ovf_o, done_o;

  int n_chk = 0, n_fail = 0;

  fpas_unit dut (.*);

  always #5 clk_i = ~clk_i;

  task automatic check(input string req, input logic [32:0] got, input logic [32:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  // behavioural model of R1..R10
  function automatic logic [32:0] model(input logic [31:0] x, input logic [31:0] y, input bit sub);
    int e1, e2, d, tmpe;
    logic [31:0] f1, f2, s, t, r;
    f1 = x & 32'hFFFFFF00; e1 = x[0] ? int'(x[7:1]) - 128 : int'(x[7:1]);
    f2 = y & 32'hFFFFFF00; e2 = y[0] ? int'(y[7:1]) - 128 : int'(y[7:1]);
    if (sub) begin
      f2 = ~f2 + 32'd1;
      if (f2 == 32'h80000000) begin f2 = 32'h40000000; e2++; end
    end
    if (f1 == 0) begin f1 = f2; e1 = e2; end
    else if (f2 != 0) begin
      if (e1 < e2) begin t = f1; f1 = f2; f2 = t; tmpe = e1; e1 = e2; e2 = tmpe; end
      d = e1 - e2;
      if (d <= 24) begin
        t = 32'($signed(f2) >>> d);
        s = f1 + t;
        if (f1[31] == t[31]) begin
          if (t[31] && !s[31]) begin s = {1'b1, s[31:1]}; e1++; end
          else if (!t[31] && s[31]) begin s = {1'b0, s[31:1]}; e1++; end
        end
        f1 = s;
      end
    end
    if (f1 == 0) e1 = 0;
    else while (f1[31] == f1[30]) begin f1 = f1 << 1; e1--; end
    r = (f1 + (f1[31] ? 32'h7F : 32'h80)) & 32'hFFFFFF00;
    if (r[31] != f1[31]) begin r = {f1[31], r[31:1]}; e1++; end
    if (r == 0) return 33'h0;
    if (e1 < -128) return {1'b1, 32'h0};
    if (e1 > 127) return {1'b1, 32'h7FFFFFFE};
    return {1'b0, r[31:8], 7'(e1), e1 < 0 ? 1'b1 : 1'b0};
  endfunction

  task automatic run_op(input logic [31:0] x, input logic [31:0] y, input bit sub,
                        input bit flip_sub, output logic [32:0] res, output int lat);
    @(negedge clk_i);
    {a_i, b_i} = x; opnd_i = y; sub_i = sub; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (flip_sub) sub_i = ~sub;
    lat = 1;
    while (!done_o && lat < 60) begin @(negedge clk_i); lat++; end
    res = {ovf_o, a_o, b_o};
  endtask

  task automatic dir(input string req, input logic [31:0] x, input logic [31:0] y,
                     input bit sub, input logic [32:0] exp);
    logic [32:0] res; int lat;
    run_op(x, y, sub, 1'b0, res, lat);
    check(req, res, exp);
    check({req, " R11 latency"}, 33'(lat <= 40), 33'd1);
  endtask

  task automatic t_reset();
    check("R13 reset", {ovf_o, done_o, a_o, b_o}, 33'h0);
  endtask

  task automatic t_directed();
    dir("R5 R1 add 1.0+1.0", 32'h40000002, 32'h40000002, 1'b0, {1'b0, 32'h40000004});
    dir("R5 neg carry -1-1", 32'h80000000, 32'h80000000, 1'b0, {1'b0, 32'h80000002});
    dir("R8 R6 1.0-1.0", 32'h40000002, 32'h40000002, 1'b1, 33'h0);
    dir("R2 0-(-1.0)", 32'h00000000, 32'h80000000, 1'b1, {1'b0, 32'h40000002});
    dir("R3 unclean zero op1", 32'h0000000A, 32'h40000002, 1'b0, {1'b0, 32'h40000002});
    dir("R3 unclean zero op2", 32'h40000002, 32'h00000020, 1'b0, {1'b0, 32'h40000002});
    dir("R4 diff 29 keeps big", 32'h40000002, 32'h4000003C, 1'b0, {1'b0, 32'h4000003C});
    dir("R7 R4 round carry", 32'h7FFFFF00, 32'h7FFFFFD3, 1'b0, {1'b0, 32'h40000002});
    dir("R9 overflow", 32'h7FFFFFFE, 32'h7FFFFFFE, 1'b0, {1'b1, 32'h7FFFFFFE});
    dir("R10 underflow", 32'h40000001, 32'h60000001, 1'b1, {1'b1, 32'h00000000});
  endtask

  task automatic t_sub_ignored();
    logic [32:0] res; int lat;
    run_op(32'h40000002, 32'h40000002, 1'b0, 1'b1, res, lat);
    check("R12 sub change ignored", res, {1'b0, 32'h40000004});
  endtask

  task automatic t_start_busy();
    int pulses = 0;
    @(negedge clk_i);
    {a_i, b_i} = 32'h40000002; opnd_i = 32'h40000002; sub_i = 1'b0; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
    {a_i, b_i} = 32'h80000000; opnd_i = 32'h80000000; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int i = 0; i < 50; i++) begin
      if (done_o) begin
        pulses++;
        if (pulses == 1) check("R12 start while busy", {ovf_o, a_o, b_o}, {1'b0, 32'h40000004});
      end
      @(negedge clk_i);
    end
    check("R12 single done", 33'(pulses), 33'd1);
  endtask

  task automatic t_random();
    logic [32:0] res; int lat;
    logic [31:0] x, y;
    bit s;
    for (int i = 0; i < 300; i++) begin
      x = $urandom; y = $urandom; s = 1'($urandom);
      if (i % 3 == 0) y[7:0] = x[7:0] ^ 8'($urandom_range(0, 14));
      if (i % 7 == 0) y[31:8] = x[31:8];
      run_op(x, y, s, 1'b0, res, lat);
      check("R4 R6 R7 random vs model", res, model(x, y, s));
      check("R11 random latency", 33'(lat <= 40), 33'd1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_directed();
    t_sub_ignored();
    t_start_busy();
    t_random();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule